// File: doc/BRIEF.md
# Link Power State Tracker

This block follows the power management state of one serial link. It moves between seven states: a link-down pseudo-state that stands for all the training phases, the fully active state, a shallow and a deeper low-power state, a ready-for-power-removal state, an auxiliary-power-only state and a fully off state. Single-cycle event inputs drive every move. Training detail and electrical idle detection happen elsewhere. Their results arrive here as the training-done and link-failure events.

Each rising clock edge samples the events. A fixed priority settles events that arrive in the same cycle: fundamental reset first, then main power removal, then link failure, and last the events local to the current state. The outputs are the current state code and a traffic gate. The gate allows transaction-layer and data-link-layer packets only while the link is fully active. The asynchronous active-low reset is released through a synchronizer. Events are ignored until that synchronizer lets the reset go.

Top module: `lnk_pm_tracker`

## Requirements
- R1: While reset is applied and until it is released, `link_state` reads the link-down code and `traffic_ok` is low.
- R2: `fund_rst` forces link-down on the next edge from every state and overrides every other event in the same cycle.
- R3: In link-down, `train_done` moves the link to active unless a higher-priority event occurs in the same cycle.
- R4: In active, `turnoff_ack` moves to ready-for-removal. Otherwise `d3_req` moves to the deeper low-power state. Otherwise `idle_timeout` moves to the shallow low-power state.
- R5: In the shallow state, `wake_req` returns to active. Otherwise `idle_timeout` or `d3_req` moves on to the deeper state.
- R6: In the deeper state, only `wake_req` returns to active. `idle_timeout`, `d3_req`, `turnoff_ack` and `train_done` have no effect there.
- R7: In ready-for-removal, `main_pwr_off` moves to auxiliary-power. The local events have no effect there.
- R8: The auxiliary-power and fully off states are left only through `fund_rst`. All other events leave them unchanged.
- R9: `main_pwr_off` in link-down, active, shallow or deeper moves to fully off, and it takes priority over `link_fail`.
- R10: `link_fail` in active, shallow, deeper or ready-for-removal returns to link-down and takes priority over the local events. In link-down it keeps link-down.
- R11: `traffic_ok` is high exactly in the cycles where `link_state` is active.
- R12: State codes on `link_state`: 0 link-down, 1 active, 2 shallow, 3 deeper, 4 ready-for-removal, 5 auxiliary-power, 6 fully off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fund_rst | input | 1 | Fundamental reset asserted |
| main_pwr_off | input | 1 | Main power removed |
| link_fail | input | 1 | Link failure seen by training logic |
| train_done | input | 1 | Link training completed |
| turnoff_ack | input | 1 | Turn-off power management message acknowledged |
| d3_req | input | 1 | Software placed the device in D3 |
| idle_timeout | input | 1 | Idle timer expired |
| wake_req | input | 1 | Request to leave a low-power state |
| link_state | output | 3 | Current state code (R12) |
| traffic_ok | output | 1 | Packet traffic allowed |

## Verification
Several events can land in the same cycle, and the priority order decides the outcome. The sharpest collisions are fundamental reset against main power removal, and link failure against the local transition of the current state (for example, a turn-off acknowledge in active). The bench forces these directly: it raises both events together from each state of interest. Random stimulus also raises events often enough that overlaps are common. After each edge, the bench compares the state with a reference model that applies the priority order written in the requirements.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_DOWN    = 3'd0,
    ST_ACTIVE  = 3'd1,
    ST_SHALLOW = 3'd2,
    ST_DEEP    = 3'd3,
    ST_READY   = 3'd4,
    ST_AUX     = 3'd5,
    ST_OFF     = 3'd6
  } lnk_state_e;

  typedef struct packed {
    logic fund_rst;
    logic pwr_off;
    logic fail;
    logic trained;
    logic tack;
    logic d3;
    logic idle;
    logic wake;
  } lnk_evt_t;

  // States in which the link still has main power and can fail
  function automatic logic is_powered(lnk_state_e s);
    return (s != ST_AUX) && (s != ST_OFF);
  endfunction

endpackage

// File: rtl/lnk_rst_sync.sv
module lnk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/lnk_next_state.sv
module lnk_next_state
  import lnk_pkg::*;
(
  input  lnk_state_e cur,
  input  lnk_evt_t   ev,
  output lnk_state_e nxt
);
  lnk_state_e local_nxt;

  // Transitions owned by the current state alone
  always_comb begin
    local_nxt = cur;
    unique case (cur)
      ST_DOWN:    if (ev.trained) local_nxt = ST_ACTIVE;
      ST_ACTIVE: begin
        if (ev.tack)      local_nxt = ST_READY;
        else if (ev.d3)   local_nxt = ST_DEEP;
        else if (ev.idle) local_nxt = ST_SHALLOW;
      end
      ST_SHALLOW: begin
        if (ev.wake)                local_nxt = ST_ACTIVE;
        else if (ev.idle || ev.d3)  local_nxt = ST_DEEP;
      end
      ST_DEEP:    if (ev.wake) local_nxt = ST_ACTIVE;
      ST_READY, ST_AUX, ST_OFF: local_nxt = cur;
      default:    local_nxt = ST_DOWN;
    endcase
  end

  // Global events in priority order
  always_comb begin
    if (ev.fund_rst) begin
      nxt = ST_DOWN;
    end else if (ev.pwr_off) begin
      if (cur == ST_READY || cur == ST_AUX) nxt = ST_AUX;
      else                                  nxt = ST_OFF;
    end else if (ev.fail && is_powered(cur)) begin
      nxt = ST_DOWN;
    end else begin
      nxt = local_nxt;
    end
  end
endmodule

// File: rtl/lnk_out_decode.sv
module lnk_out_decode
  import lnk_pkg::*;
(
  input  lnk_state_e        st,
  output logic [ST_W-1:0]   state_code,
  output logic              traffic_ok
);
  assign state_code = st;
  assign traffic_ok = (st == ST_ACTIVE);
endmodule

// File: rtl/lnk_pm_tracker.sv
module lnk_pm_tracker
  import lnk_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fund_rst,
  input  logic            main_pwr_off,
  input  logic            link_fail,
  input  logic            train_done,
  input  logic            turnoff_ack,
  input  logic            d3_req,
  input  logic            idle_timeout,
  input  logic            wake_req,
  output logic [ST_W-1:0] link_state,
  output logic            traffic_ok
);
  logic       rst_sync_n;
  lnk_evt_t   ev;
  lnk_state_e st_q, st_nxt;
  logic       st_en;

  lnk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ev.fund_rst = fund_rst;
    ev.pwr_off  = main_pwr_off;
    ev.fail     = link_fail;
    ev.trained  = train_done;
    ev.tack     = turnoff_ack;
    ev.d3       = d3_req;
    ev.idle     = idle_timeout;
    ev.wake     = wake_req;
  end

  lnk_next_state u_nxt (
    .cur (st_q),
    .ev  (ev),
    .nxt (st_nxt)
  );

  assign st_en = (st_nxt != st_q);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  st_q <= ST_DOWN;
    else if (st_en)   st_q <= st_nxt;
  end

  lnk_out_decode u_out (
    .st         (st_q),
    .state_code (link_state),
    .traffic_ok (traffic_ok)
  );
endmodule

// File: rtl/lnk_pm_tracker_chk.sv
module lnk_pm_tracker_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       fund_rst,
  input logic       main_pwr_off,
  input logic       link_fail,
  input logic       turnoff_ack,
  input logic [2:0] link_state,
  input logic       traffic_ok
);
  p_fund_rst_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    fund_rst |=> (link_state == 3'd0));

  p_aux_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (link_state == 3'd5 && !fund_rst) |=> (link_state == 3'd5));

  p_off_hold_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (link_state == 3'd6 && !fund_rst) |=> (link_state == 3'd6));

  p_pwr_off_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (link_state <= 3'd3 && main_pwr_off && !fund_rst) |=> (link_state == 3'd6));

  p_ready_entry_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (link_state == 3'd1 && turnoff_ack && !fund_rst && !main_pwr_off && !link_fail)
      |=> (link_state == 3'd4));

  p_fail_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (link_state <= 3'd4 && link_fail && !fund_rst && !main_pwr_off)
      |=> (link_state == 3'd0));

  p_traffic_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    traffic_ok |-> (link_state == 3'd1));

  p_code_r12: assert property (@(posedge clk) disable iff (!rst_ok)
    link_state != 3'd7);
endmodule

bind lnk_pm_tracker lnk_pm_tracker_chk u_chk (
  .clk          (clk),
  .rst_ok       (rst_sync_n),
  .fund_rst     (fund_rst),
  .main_pwr_off (main_pwr_off),
  .link_fail    (link_fail),
  .turnoff_ack  (turnoff_ack),
  .link_state   (link_state),
  .traffic_ok   (traffic_ok)
);

// File: tb/lnk_pm_tracker_test.sv
module lnk_pm_tracker_test;
  localparam logic [2:0] S_DOWN = 3'd0, S_ACT = 3'd1, S_SHL = 3'd2, S_DEEP = 3'd3,
                         S_RDY = 3'd4, S_AUX = 3'd5, S_OFF = 3'd6;
  // event vector bit order: fr, po, lf, td, ta, d3, it, wk
  localparam logic [7:0] E_FR = 8'h80, E_PO = 8'h40, E_LF = 8'h20, E_TD = 8'h10,
                         E_TA = 8'h08, E_D3 = 8'h04, E_IT = 8'h02, E_WK = 8'h01;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] ev;
  logic [2:0] link_state;
  logic traffic_ok;
  int total = 0, bad = 0;
  logic [2:0] model;
  logic done = 1'b0;

  always #5 clk = ~clk;

  lnk_pm_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .fund_rst(ev[7]), .main_pwr_off(ev[6]), .link_fail(ev[5]), .train_done(ev[4]),
    .turnoff_ack(ev[3]), .d3_req(ev[2]), .idle_timeout(ev[1]), .wake_req(ev[0]),
    .link_state(link_state), .traffic_ok(traffic_ok)
  );

  function automatic logic [2:0] ref_next(logic [2:0] s, logic [7:0] e);
    if (e[7]) return S_DOWN;
    if (e[6]) return (s == S_RDY || s == S_AUX) ? S_AUX : S_OFF;
    if (e[5] && s != S_AUX && s != S_OFF) return S_DOWN;
    case (s)
      S_DOWN: return e[4] ? S_ACT : s;
      S_ACT:  return e[3] ? S_RDY : e[2] ? S_DEEP : e[1] ? S_SHL : s;
      S_SHL:  return e[0] ? S_ACT : (e[1] || e[2]) ? S_DEEP : s;
      S_DEEP: return e[0] ? S_ACT : s;
      default: return s;
    endcase
  endfunction

  function automatic string req_of(logic [2:0] s, logic [7:0] e);
    if (e[7]) return "R2";
    if (e[6]) return (s == S_RDY) ? "R7" : (s >= S_AUX) ? "R8" : "R9";
    if (e[5] && s <= S_RDY) return "R10";
    case (s)
      S_DOWN: return "R3";
      S_ACT:  return "R4";
      S_SHL:  return "R5";
      S_DEEP: return "R6";
      S_RDY:  return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] exp_st);
    total++;
    if (link_state !== exp_st) begin
      bad++;
      $display("FAIL %s state actual=%0d expected=%0d", req, link_state, exp_st);
    end
    total++;
    if (traffic_ok !== (exp_st == S_ACT)) begin
      bad++;
      $display("FAIL R11 traffic_ok actual=%0b expected=%0b (state %0d)",
               traffic_ok, exp_st == S_ACT, exp_st);
    end
  endtask

  // drive at negedge, one posedge, sample at the following negedge
  task automatic step(logic [7:0] e);
    string r;
    r = req_of(model, e);
    ev = e;
    @(posedge clk);
    @(negedge clk);
    model = ref_next(model, e);
    check(r, model);
    ev = '0;
  endtask

  task automatic go(logic [2:0] target);
    step(E_FR);
    step(E_TD);
    case (target)
      S_SHL:  step(E_IT);
      S_DEEP: step(E_D3);
      S_RDY:  step(E_TA);
      S_AUX:  begin step(E_TA); step(E_PO); end
      S_OFF:  step(E_PO);
      default: ;
    endcase
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1badcafe));
    ev = '0;
    rst_n = 1'b0;
    model = S_DOWN;
    repeat (3) @(negedge clk);
    check("R1", S_DOWN);
    ev = E_TD;               // ignored while reset holds
    @(negedge clk);
    check("R1", S_DOWN);
    ev = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", S_DOWN);

    // R12 codes and R3/R4/R5/R6 basic walk
    step(E_TD);            // active
    step(E_IT);            // shallow
    step(E_WK);            // active
    step(E_IT); step(E_IT);// shallow -> deep
    step(E_IT | E_D3 | E_TA | E_TD); // R6 ignored
    step(E_WK);            // active
    step(E_TA | E_D3 | E_IT); // R4 turn-off wins -> ready
    step(E_TD | E_D3 | E_IT | E_WK | E_TA); // R7 ignored
    step(E_PO | E_LF);     // R7 -> aux
    step(E_LF | E_TD | E_WK | E_PO); // R8 held
    step(E_FR | E_PO);     // R2 wins -> down

    // collisions
    go(S_ACT);  step(E_LF | E_TA);         // R10 over local
    go(S_DEEP); step(E_PO | E_LF);         // R9 over fail
    step(E_LF | E_WK | E_TD);              // R8 off held
    go(S_SHL);  step(E_D3 | E_WK);         // R5 wake wins
    go(S_ACT);  step(E_D3 | E_IT);         // R4 d3 over idle
    go(S_RDY);  step(E_LF);                // R10 ready fails
    step(E_LF | E_TD);                     // R10 fail over train
    go(S_AUX);  step(E_FR | E_PO | E_LF);  // R2

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] e;
      e = '0;
      e[7] = ($urandom_range(0, 39) == 0);
      e[6] = ($urandom_range(0, 29) == 0);
      e[5] = ($urandom_range(0, 24) == 0);
      for (int b = 0; b < 5; b++) e[b] = ($urandom_range(0, 3) == 0);
      step(e);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule